// File: doc/BRIEF.md
# Four-Bank DDR SDRAM Command Legality Tracker

This block watches the command pins of a four-bank double-data-rate SDRAM. Every cycle it decodes chip select, RAS, CAS, WE, the bank address and the auto-precharge address bit. It keeps a state machine for every bank: closed, opening, open, read burst, write burst, read or write burst with auto-precharge, closing, and write recovery (plain, or followed by auto-precharge). It also keeps a device-wide wait after a refresh or a mode-register write.

For each command the block reports, one cycle later, whether the command is legal in the current state and which action it causes. An illegal command is dropped and changes no state.

All waits are counted in whole clock cycles. The counts come from input ports, so a controller can check itself against the timing it actually uses. Each bank has its own down-counter.

Top module: `sdram_bank_checker`

## Requirements
- R1: Commands decode from {cs_n,ras_n,cas_n,we_n} as follows: cs_n=1 deselect; 0111 no-op; 0110 burst stop; 0101 read; 0100 write; 0011 activate; 0010 precharge; 0001 refresh; 0000 mode write. Deselect and no-op are always legal, report action 0 and change nothing.
- R2: While reset is low, every bank reads state 0, `dev_busy` is 0, `cmd_illegal` is 0 and `cmd_action` is 0.
- R3: Activate is legal only when the addressed bank is closed (state 0). The bank then reads opening (1) for max(t_rcd,1) cycles and then open (2). The action code is 1.
- R4: Read or write is legal only when the addressed bank is open (2). With addr_ap=0 the bank enters read (3) or write (4), with action 2 or 3. With addr_ap=1 it enters read-AP (5) or write-AP (6), with action 10 or 11. Each burst lasts max(burst_cyc,1) cycles.
- R5: A read burst ends in open (2). A write burst ends in recovery (8), which lasts max(t_wr,1) cycles and then returns to open (2).
- R6: Read-AP ends in closing (7). Write-AP ends in recovery-AP (9) for max(t_wr,1) cycles and then closing (7). Closing lasts max(t_rp,1) cycles and then the bank is closed (0). No command can interrupt states 5 and 6.
- R7: Precharge with addr_ap=0 acts on the addressed bank. On a closed bank it is legal with action 9 and changes nothing. In states 2, 3 or 4 it ends any burst, enters closing (7) and gives action 4. In any other state it is illegal.
- R8: Precharge with addr_ap=1 ignores the bank address. It is legal only if every bank is in state 0, 2, 3 or 4. It then reports action 5, and every bank that is not closed enters closing (7).
- R9: Burst stop is legal only when the addressed bank is in read (3). The bank then returns to open (2) at once, and the action is 6.
- R10: Refresh (action 7) and mode write (action 8) are legal only when all banks are closed and no device wait runs. They start a device wait of max(t_rfc,1) or max(t_mrd,1) cycles, shown on `dev_busy`. During that wait every command other than deselect and no-op is illegal.
- R11: An illegal command reports action 15 and changes neither bank states nor the device wait.
- R12: The verdict and the action for a command on the pins at a rising edge appear on `cmd_illegal` and `cmd_action` right after that edge. They hold for one cycle. Bank states and `dev_busy` update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW | Bank address |
| addr_ap | input | 1 | Auto-precharge / all-banks select bit |
| t_rcd | input | CW | Activate-to-open wait in cycles |
| t_rp | input | CW | Precharge wait in cycles |
| t_wr | input | CW | Write recovery wait in cycles |
| t_mrd | input | CW | Mode write wait in cycles |
| t_rfc | input | CW | Refresh wait in cycles |
| burst_cyc | input | CW | Burst length in cycles |
| cmd_illegal | output | 1 | Verdict for the previous cycle's command |
| cmd_action | output | 4 | Action code for the previous cycle's command |
| bank_state | output | NB*4 | Packed per-bank state codes, bank 0 in the lowest bits |
| dev_busy | output | 1 | Device-wide wait running |

## Verification
The verdict and action for a command are due one edge after the command is driven. Bank state and `dev_busy` change on that same edge. The bench drives each command just after a falling edge and samples every output at the next falling edge. It compares them there with a cycle model built from the requirements. That model advances every wait counter once per step, so each wait of max(N,1) cycles is checked to the exact cycle in which its state ends.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [3:0] {
    BS_IDLE     = 4'd0,
    BS_OPENING  = 4'd1,
    BS_OPEN     = 4'd2,
    BS_RD       = 4'd3,
    BS_WR       = 4'd4,
    BS_RD_AP    = 4'd5,
    BS_WR_AP    = 4'd6,
    BS_PRECH    = 4'd7,
    BS_RECOV    = 4'd8,
    BS_RECOV_AP = 4'd9
  } bank_st_e;

  typedef enum logic [3:0] {
    AC_NONE    = 4'd0,
    AC_ACT     = 4'd1,
    AC_RD      = 4'd2,
    AC_WR      = 4'd3,
    AC_PRE     = 4'd4,
    AC_PRE_ALL = 4'd5,
    AC_STOP    = 4'd6,
    AC_REF     = 4'd7,
    AC_MODE    = 4'd8,
    AC_NOOP    = 4'd9,
    AC_RD_AP   = 4'd10,
    AC_WR_AP   = 4'd11,
    AC_REJECT  = 4'd15
  } action_e;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_BST, CMD_RD, CMD_WR,
    CMD_ACT, CMD_PRE, CMD_REF, CMD_MRS
  } cmd_e;

  localparam int STATE_W = $bits(bank_st_e);

endpackage

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
  import sdram_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_judge.sv
module sdram_cmd_judge
  import sdram_chk_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BAW = 2
) (
  input  cmd_e                  cmd,
  input  logic [BAW-1:0]        ba,
  input  logic                  ap,
  input  logic [NB*STATE_W-1:0] bank_state,
  input  logic                  dev_busy,
  output logic                  illegal,
  output action_e               action,
  output logic [NB-1:0]         ev_act,
  output logic [NB-1:0]         ev_rd,
  output logic [NB-1:0]         ev_wr,
  output logic [NB-1:0]         ev_pre,
  output logic [NB-1:0]         ev_bst,
  output logic                  ev_ref,
  output logic                  ev_mrs
);

  bank_st_e st_a [NB];
  bank_st_e tgt;
  logic     all_idle;
  logic     all_breakable;

  // A bank may be closed by a precharge only while idle, open or in a plain burst.
  function automatic logic breakable(input bank_st_e s);
    return (s == BS_IDLE) || (s == BS_OPEN) || (s == BS_RD) || (s == BS_WR);
  endfunction

  always_comb begin
    all_idle      = 1'b1;
    all_breakable = 1'b1;
    for (int i = 0; i < NB; i++) begin
      st_a[i] = bank_st_e'(bank_state[i*STATE_W +: STATE_W]);
      if (st_a[i] != BS_IDLE) all_idle = 1'b0;
      if (!breakable(st_a[i])) all_breakable = 1'b0;
    end
    tgt = st_a[ba];
  end

  always_comb begin
    illegal = 1'b0;
    action  = AC_NONE;
    ev_act  = '0;
    ev_rd   = '0;
    ev_wr   = '0;
    ev_pre  = '0;
    ev_bst  = '0;
    ev_ref  = 1'b0;
    ev_mrs  = 1'b0;
    if (cmd != CMD_DESEL && cmd != CMD_NOP) begin
      if (dev_busy) begin
        illegal = 1'b1;
      end else begin
        unique case (cmd)
          CMD_ACT: begin
            if (tgt == BS_IDLE) begin
              action     = AC_ACT;
              ev_act[ba] = 1'b1;
            end else illegal = 1'b1;
          end
          CMD_RD: begin
            if (tgt == BS_OPEN) begin
              action    = ap ? AC_RD_AP : AC_RD;
              ev_rd[ba] = 1'b1;
            end else illegal = 1'b1;
          end
          CMD_WR: begin
            if (tgt == BS_OPEN) begin
              action    = ap ? AC_WR_AP : AC_WR;
              ev_wr[ba] = 1'b1;
            end else illegal = 1'b1;
          end
          CMD_BST: begin
            if (tgt == BS_RD) begin
              action     = AC_STOP;
              ev_bst[ba] = 1'b1;
            end else illegal = 1'b1;
          end
          CMD_PRE: begin
            if (ap) begin
              if (all_breakable) begin
                action = AC_PRE_ALL;
                for (int i = 0; i < NB; i++) ev_pre[i] = (st_a[i] != BS_IDLE);
              end else illegal = 1'b1;
            end else if (tgt == BS_IDLE) begin
              action = AC_NOOP;
            end else if (breakable(tgt)) begin
              action     = AC_PRE;
              ev_pre[ba] = 1'b1;
            end else illegal = 1'b1;
          end
          CMD_REF: begin
            if (all_idle) begin
              action = AC_REF;
              ev_ref = 1'b1;
            end else illegal = 1'b1;
          end
          default: begin
            if (all_idle) begin
              action = AC_MODE;
              ev_mrs = 1'b1;
            end else illegal = 1'b1;
          end
        endcase
      end
    end
    if (illegal) action = AC_REJECT;
  end

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_chk_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_act,
  input  logic          ev_rd,
  input  logic          ev_wr,
  input  logic          ev_pre,
  input  logic          ev_bst,
  input  logic          ap,
  input  logic [CW-1:0] t_rcd,
  input  logic [CW-1:0] t_rp,
  input  logic [CW-1:0] t_wr,
  input  logic [CW-1:0] burst_cyc,
  output bank_st_e      state_o
);

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;
  logic          en;

  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] n);
    return (n == '0) ? CW'(1) : n;
  endfunction

  assign last = (cnt_q <= CW'(1));
  assign en   = (st_q != BS_IDLE) || ev_act;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q - CW'(1);
    unique case (st_q)
      BS_IDLE: begin
        cnt_d = cnt_q;
        if (ev_act) begin
          st_d  = BS_OPENING;
          cnt_d = at_least_one(t_rcd);
        end
      end
      BS_OPENING: if (last) st_d = BS_OPEN;
      BS_OPEN: begin
        cnt_d = cnt_q;
        if (ev_rd) begin
          st_d  = ap ? BS_RD_AP : BS_RD;
          cnt_d = at_least_one(burst_cyc);
        end else if (ev_wr) begin
          st_d  = ap ? BS_WR_AP : BS_WR;
          cnt_d = at_least_one(burst_cyc);
        end else if (ev_pre) begin
          st_d  = BS_PRECH;
          cnt_d = at_least_one(t_rp);
        end
      end
      BS_RD: begin
        if (ev_pre) begin
          st_d  = BS_PRECH;
          cnt_d = at_least_one(t_rp);
        end else if (ev_bst || last) begin
          st_d = BS_OPEN;
        end
      end
      BS_WR: begin
        if (ev_pre) begin
          st_d  = BS_PRECH;
          cnt_d = at_least_one(t_rp);
        end else if (last) begin
          st_d  = BS_RECOV;
          cnt_d = at_least_one(t_wr);
        end
      end
      BS_RD_AP: begin
        if (last) begin
          st_d  = BS_PRECH;
          cnt_d = at_least_one(t_rp);
        end
      end
      BS_WR_AP: begin
        if (last) begin
          st_d  = BS_RECOV_AP;
          cnt_d = at_least_one(t_wr);
        end
      end
      BS_PRECH:  if (last) st_d = BS_IDLE;
      BS_RECOV:  if (last) st_d = BS_OPEN;
      BS_RECOV_AP: begin
        if (last) begin
          st_d  = BS_PRECH;
          cnt_d = at_least_one(t_rp);
        end
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_IDLE;
      cnt_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/sdram_dev_wait.sv
module sdram_dev_wait #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ref,
  input  logic          ev_mrs,
  input  logic [CW-1:0] t_rfc,
  input  logic [CW-1:0] t_mrd,
  output logic          busy
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign en = ev_ref || ev_mrs || (cnt_q != '0);

  always_comb begin
    if (ev_ref)      cnt_d = (t_rfc == '0) ? CW'(1) : t_rfc;
    else if (ev_mrs) cnt_d = (t_mrd == '0) ? CW'(1) : t_mrd;
    else             cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker
  import sdram_chk_pkg::*;
#(
  parameter int NB  = 4,
  parameter int CW  = 6,
  parameter int BAW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [BAW-1:0]        ba,
  input  logic                  addr_ap,
  input  logic [CW-1:0]         t_rcd,
  input  logic [CW-1:0]         t_rp,
  input  logic [CW-1:0]         t_wr,
  input  logic [CW-1:0]         t_mrd,
  input  logic [CW-1:0]         t_rfc,
  input  logic [CW-1:0]         burst_cyc,
  output logic                  cmd_illegal,
  output logic [3:0]            cmd_action,
  output logic [NB*STATE_W-1:0] bank_state,
  output logic                  dev_busy
);

  cmd_e          cmd;
  logic          illegal_d;
  action_e       action_d;
  logic [NB-1:0] ev_act, ev_rd, ev_wr, ev_pre, ev_bst;
  logic          ev_ref, ev_mrs;
  bank_st_e      st_w [NB];

  sdram_cmd_dec u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sdram_cmd_judge #(.NB(NB), .BAW(BAW)) u_judge (
    .cmd        (cmd),
    .ba         (ba),
    .ap         (addr_ap),
    .bank_state (bank_state),
    .dev_busy   (dev_busy),
    .illegal    (illegal_d),
    .action     (action_d),
    .ev_act     (ev_act),
    .ev_rd      (ev_rd),
    .ev_wr      (ev_wr),
    .ev_pre     (ev_pre),
    .ev_bst     (ev_bst),
    .ev_ref     (ev_ref),
    .ev_mrs     (ev_mrs)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_track #(.CW(CW)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_act    (ev_act[g]),
      .ev_rd     (ev_rd[g]),
      .ev_wr     (ev_wr[g]),
      .ev_pre    (ev_pre[g]),
      .ev_bst    (ev_bst[g]),
      .ap        (addr_ap),
      .t_rcd     (t_rcd),
      .t_rp      (t_rp),
      .t_wr      (t_wr),
      .burst_cyc (burst_cyc),
      .state_o   (st_w[g])
    );
    assign bank_state[g*STATE_W +: STATE_W] = st_w[g];
  end

  sdram_dev_wait #(.CW(CW)) u_dev (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_ref (ev_ref),
    .ev_mrs (ev_mrs),
    .t_rfc  (t_rfc),
    .t_mrd  (t_mrd),
    .busy   (dev_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_illegal <= 1'b0;
      cmd_action  <= AC_NONE;
    end else begin
      cmd_illegal <= illegal_d;
      cmd_action  <= action_d;
    end
  end

endmodule

// File: rtl/sdram_bank_checker_sva.sv
module sdram_bank_checker_sva
  import sdram_chk_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BAW = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n,
  input logic                  ras_n,
  input logic                  cas_n,
  input logic                  we_n,
  input logic [BAW-1:0]        ba,
  input logic                  cmd_illegal,
  input logic [NB*STATE_W-1:0] bank_state,
  input logic                  dev_busy
);

  logic [STATE_W-1:0] st [NB];
  logic quiet, is_rw, is_bst, is_act, is_refmrs, all_idle;

  assign quiet     = cs_n || (ras_n && cas_n && we_n);
  assign is_rw     = !cs_n && ras_n && !cas_n;
  assign is_bst    = !cs_n && ras_n && cas_n && !we_n;
  assign is_act    = !cs_n && !ras_n && cas_n && we_n;
  assign is_refmrs = !cs_n && !ras_n && !cas_n;

  for (genvar g = 0; g < NB; g++) begin : g_unpack
    assign st[g] = bank_state[g*STATE_W +: STATE_W];
  end

  always_comb begin
    all_idle = 1'b1;
    for (int i = 0; i < NB; i++) if (st[i] != BS_IDLE) all_idle = 1'b0;
  end

  assert_busy_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_busy && !quiet) |=> cmd_illegal);

  assert_refmrs_needs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_refmrs && !all_idle) |=> cmd_illegal);

  assert_rw_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && st[ba] != BS_OPEN) |=> cmd_illegal);

  assert_stop_only_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bst && st[ba] != BS_RD) |=> cmd_illegal);

  for (genvar g = 0; g < NB; g++) begin : g_bank_props
    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == BS_IDLE && !(is_act && ba == BAW'(g))) |=> st[g] == BS_IDLE);

    assert_write_to_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == BS_WR) |=> (st[g] == BS_WR || st[g] == BS_RECOV || st[g] == BS_PRECH));

    assert_ap_read_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == BS_RD_AP) |=> (st[g] == BS_RD_AP || st[g] == BS_PRECH));
  end

endmodule

bind sdram_bank_checker sdram_bank_checker_sva #(.NB(NB), .BAW(BAW)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .cmd_illegal (cmd_illegal),
  .bank_state  (bank_state),
  .dev_busy    (dev_busy)
);

// File: tb/sdram_bank_checker_test.sv
module sdram_bank_checker_test;

  localparam int NB = 4;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, ras_n, cas_n, we_n, addr_ap;
  logic [1:0] ba;
  logic [CW-1:0] t_rcd, t_rp, t_wr, t_mrd, t_rfc, burst_cyc;
  logic cmd_illegal, dev_busy;
  logic [3:0] cmd_action;
  logic [NB*4-1:0] bank_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int ms [NB];
  int mc [NB];
  int dc;

  always #2 clk = ~clk;

  sdram_bank_checker #(.NB(NB), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr_ap(addr_ap), .t_rcd(t_rcd), .t_rp(t_rp),
    .t_wr(t_wr), .t_mrd(t_mrd), .t_rfc(t_rfc), .burst_cyc(burst_cyc),
    .cmd_illegal(cmd_illegal), .cmd_action(cmd_action),
    .bank_state(bank_state), .dev_busy(dev_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int at1(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic bit brk(input int s);
    return (s == 0) || (s == 2) || (s == 3) || (s == 4);
  endfunction

  // Cycle model of the requirements: verdict first, then one step of every wait.
  task automatic model(input int c, input int b, input int ap, output int ill, output int act);
    bit ea[NB], er[NB], ew[NB], ep[NB], eb[NB];
    bit eref, emrs, allidle, allbrk;
    ill = 0; act = 0; eref = 0; emrs = 0; allidle = 1; allbrk = 1;
    for (int i = 0; i < NB; i++) begin
      ea[i] = 0; er[i] = 0; ew[i] = 0; ep[i] = 0; eb[i] = 0;
      if (ms[i] != 0) allidle = 0;
      if (!brk(ms[i])) allbrk = 0;
    end
    if (c >= 2) begin
      if (dc != 0) ill = 1;
      else case (c)
        2: if (ms[b] == 3) begin act = 6; eb[b] = 1; end else ill = 1;
        3: if (ms[b] == 2) begin act = ap ? 10 : 2; er[b] = 1; end else ill = 1;
        4: if (ms[b] == 2) begin act = ap ? 11 : 3; ew[b] = 1; end else ill = 1;
        5: if (ms[b] == 0) begin act = 1; ea[b] = 1; end else ill = 1;
        6: begin
          if (ap != 0) begin
            if (allbrk) begin
              act = 5;
              for (int i = 0; i < NB; i++) ep[i] = (ms[i] != 0);
            end else ill = 1;
          end else if (ms[b] == 0) act = 9;
          else if (brk(ms[b])) begin act = 4; ep[b] = 1; end
          else ill = 1;
        end
        7: if (allidle) begin act = 7; eref = 1; end else ill = 1;
        default: if (allidle) begin act = 8; emrs = 1; end else ill = 1;
      endcase
    end
    if (ill != 0) act = 15;
    for (int i = 0; i < NB; i++) begin
      int s, n;
      s = ms[i]; n = mc[i];
      case (s)
        0: if (ea[i]) begin s = 1; n = at1(int'(t_rcd)); end
        1: if (n <= 1) s = 2; else n--;
        2: if (er[i]) begin s = ap ? 5 : 3; n = at1(int'(burst_cyc)); end
           else if (ew[i]) begin s = ap ? 6 : 4; n = at1(int'(burst_cyc)); end
           else if (ep[i]) begin s = 7; n = at1(int'(t_rp)); end
        3: if (ep[i]) begin s = 7; n = at1(int'(t_rp)); end
           else if (eb[i] || n <= 1) s = 2; else n--;
        4: if (ep[i]) begin s = 7; n = at1(int'(t_rp)); end
           else if (n <= 1) begin s = 8; n = at1(int'(t_wr)); end else n--;
        5: if (n <= 1) begin s = 7; n = at1(int'(t_rp)); end else n--;
        6: if (n <= 1) begin s = 9; n = at1(int'(t_wr)); end else n--;
        7: if (n <= 1) s = 0; else n--;
        8: if (n <= 1) s = 2; else n--;
        default: if (n <= 1) begin s = 7; n = at1(int'(t_rp)); end else n--;
      endcase
      ms[i] = s; mc[i] = n;
    end
    if (eref) dc = at1(int'(t_rfc));
    else if (emrs) dc = at1(int'(t_mrd));
    else if (dc > 0) dc--;
  endtask

  // Commands: 0 deselect, 1 no-op, 2 stop, 3 read, 4 write, 5 activate, 6 precharge, 7 refresh, 8 mode.
  task automatic step(input int c, input int b, input int ap, input string tag);
    int ei, ea;
    cs_n = (c == 0);
    case (c)
      0, 1: {ras_n, cas_n, we_n} = 3'b111;
      2: {ras_n, cas_n, we_n} = 3'b110;
      3: {ras_n, cas_n, we_n} = 3'b101;
      4: {ras_n, cas_n, we_n} = 3'b100;
      5: {ras_n, cas_n, we_n} = 3'b011;
      6: {ras_n, cas_n, we_n} = 3'b010;
      7: {ras_n, cas_n, we_n} = 3'b001;
      default: {ras_n, cas_n, we_n} = 3'b000;
    endcase
    if (c == 0) {ras_n, cas_n, we_n} = 3'($urandom);
    ba = 2'(b);
    addr_ap = (ap != 0);
    model(c, b, ap, ei, ea);
    @(negedge clk);
    chk(int'(cmd_illegal) == ei, {tag, " R12 verdict"}, int'(cmd_illegal), ei);
    chk(int'(cmd_action) == ea, {tag, " R12 action"}, int'(cmd_action), ea);
    for (int i = 0; i < NB; i++)
      chk(int'(bank_state[i*4 +: 4]) == ms[i], {tag, " R5/R6 bank state"},
          int'(bank_state[i*4 +: 4]), ms[i]);
    chk(int'(dev_busy) == int'(dc != 0), {tag, " R10 busy"}, int'(dev_busy), int'(dc != 0));
  endtask

  task automatic idle_for(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1, 0, 0, tag);
  endtask

  task automatic random_run(input int n);
    for (int k = 0; k < n; k++) begin
      int r, c;
      r = int'($urandom % 16);
      if (r < 8) c = 1;
      else if (r == 8) c = 0;
      else c = 2 + int'($urandom % 7);
      step(c, int'($urandom % 4), int'(($urandom % 4) == 0), "random R1");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = '0; addr_ap = 1'b0;
    t_rcd = 6'd3; t_rp = 6'd2; t_wr = 6'd2; t_mrd = 6'd2; t_rfc = 6'd4; burst_cyc = 6'd2;
    for (int i = 0; i < NB; i++) begin ms[i] = 0; mc[i] = 0; end
    dc = 0;
    repeat (3) @(negedge clk);
    chk(bank_state == '0, "R2 reset banks", int'(bank_state), 0);
    chk(!dev_busy && !cmd_illegal && cmd_action == 4'd0, "R2 reset flags",
        int'({dev_busy, cmd_illegal, cmd_action}), 0);
    rst_n = 1'b1;

    step(1, 0, 0, "R1 nop");
    step(0, 2, 1, "R1 deselect");
    step(3, 0, 0, "R4 R11 read closed bank");
    step(5, 0, 0, "R3 activate");
    step(3, 0, 0, "R4 R11 read while opening");
    idle_for(3, "R3 opening wait");
    step(3, 0, 1, "R4 read auto-precharge");
    step(6, 1, 1, "R8 R11 precharge-all during read-AP");
    step(2, 0, 0, "R9 stop on read-AP");
    idle_for(6, "R6 read-AP to idle");
    step(5, 1, 0, "R3 activate bank1");
    idle_for(3, "R3 opening wait");
    step(4, 1, 0, "R4 write");
    step(2, 1, 0, "R9 stop during write");
    idle_for(2, "R5 write end");
    step(7, 0, 0, "R10 refresh with open bank");
    idle_for(2, "R5 recovery end");
    step(6, 1, 0, "R7 precharge open bank");
    step(6, 1, 0, "R7 precharge closing bank");
    idle_for(2, "R7 closing wait");
    step(6, 2, 0, "R7 precharge idle bank");
    step(5, 2, 0, "R3 activate bank2");
    idle_for(3, "R3 opening wait");
    step(3, 2, 0, "R4 read bank2");
    step(2, 2, 0, "R9 stop read");
    step(4, 2, 1, "R4 write auto-precharge");
    step(6, 3, 1, "R8 precharge-all during write-AP");
    idle_for(7, "R6 write-AP to idle");
    step(5, 3, 0, "R3 activate bank3");
    idle_for(3, "R3 opening wait");
    step(6, 0, 1, "R8 precharge-all ignores bank");
    idle_for(3, "R8 closing");
    step(8, 0, 0, "R10 mode write");
    step(5, 0, 0, "R10 activate during mode wait");
    idle_for(2, "R10 mode wait");
    step(7, 0, 0, "R10 refresh");
    step(7, 0, 0, "R10 refresh during wait");
    idle_for(4, "R10 refresh wait");

    random_run(4000);
    t_rcd = 6'd0; t_rp = 6'd1; t_wr = 6'd0; t_mrd = 6'd0; t_rfc = 6'd1; burst_cyc = 6'd0;
    random_run(3000);
    t_rcd = 6'd5; t_rp = 6'd4; t_wr = 6'd3; t_mrd = 6'd3; t_rfc = 6'd9; burst_cyc = 6'd4;
    random_run(4000);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule